// File: doc/BRIEF.md
# Serial Flash Read Responder

This block plays the memory side of a four-wire serial flash link, and it answers read commands only. While chip select is low, it takes one bit from `mosi` on each rising edge of `sck`. The first eight bits form a command byte. A read command is followed by a header whose length depends on the kind of read. When the header is complete, the block sends bytes back on `sdo_dat`, with `sdo_oe` marking when the pin is driven. Any command byte that is not a read causes the rest of the transaction to be ignored.

There are three kinds of read:
- A sweep across the whole main array.
- A read that stays inside one page of the main array.
- A read of the separate page-sized buffer.

All three share one front end. They differ in how long the header is and in how the address moves on after the last byte of a page or of the buffer. Both storage arrays are register arrays inside the block. A parallel backdoor port fills them before a test. All pins are sampled on the system clock, so `sck` must run at no more than a quarter of the `clk` rate.

Top module: `sflash_read_resp`

## Requirements
- R1: Command bytes 68h and E8h start an array sweep. The header is 24 address bits and then 32 don't-care bits. The address is {6 ignored bits, 9-bit page, 9-bit byte offset}, and the page is taken modulo NUM_PAGES. The first data bit appears after the first `sck` falling edge that follows the last header bit, and `sdo_oe` is then high.
- R2: Command bytes 52h and D2h start a single-page read. It uses the same header and address layout as R1.
- R3: Command bytes 54h and D4h start a buffer read. The header is 15 don't-care bits, then a 9-bit buffer offset, then 8 don't-care bits.
- R4: Each byte is sent MSB first. `sdo_dat` changes only after an `sck` falling edge and holds steady through the rising edge that follows.
- R5: In an array sweep, the byte after offset PAGE_BYTES-1 is offset 0 of the next page, with no idle bit between them.
- R6: In an array sweep, the byte after the last byte of page NUM_PAGES-1 is page 0, offset 0, again with no gap.
- R7: In a single-page read, the byte after offset PAGE_BYTES-1 is offset 0 of the same page.
- R8: In a buffer read, the byte after offset PAGE_BYTES-1 is buffer offset 0.
- R9: If chip select goes high at any point, the command ends. `sdo_oe` is low one `clk` cycle later, and the next low period of chip select starts a fresh command byte.
- R10: After any command byte not listed in R1 to R3, `sdo_oe` stays low for the rest of that chip-select period.
- R11: Reads of the main array never change the contents of the buffer.
- R12: While `rst` is high and after it is released, `sdo_oe` and `sdo_dat` are 0.
- R13: When `bd_we` is high, `bd_wdata` is written at `bd_addr`. With `bd_sel_buf` high the target is buffer offset `bd_addr`. With it low the target is main byte page*PAGE_BYTES+offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| sdo_dat | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for the serial data pad; low means high impedance |
| bd_we | input | 1 | Backdoor write strobe |
| bd_sel_buf | input | 1 | Backdoor target: 1 buffer, 0 main array |
| bd_addr | input | MAIN_AW | Backdoor byte address |
| bd_wdata | input | 8 | Backdoor write data |

## Verification
The checker covers four properties on every clock:
- `sdo_oe` drops one cycle after chip select goes high.
- The data bit moves only on cycles that carry an `sck` falling edge.
- `sdo_oe` is high only while the front end is in its data phase.
- The pointer changes by the correct rule on each step: it moves to the next page, or wraps to page 0, on an array crossover, and keeps the same page in the other two modes.

Only the bench scenarios can show the rest:
- Byte values and bit order.
- Decoding of all six command bytes and of the header layouts, including ignored reserved bits and page folding.
- Recovery after an aborted command or an unknown command.
- That the buffer still holds its data after main-array reads.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic [1:0] {
        MODE_NONE  = 2'd0,
        MODE_ARRAY = 2'd1,
        MODE_PAGE  = 2'd2,
        MODE_BUF   = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        FE_OPC  = 2'd0,
        FE_HDR  = 2'd1,
        FE_DATA = 2'd2,
        FE_SKIP = 2'd3
    } fe_state_e;

    typedef struct packed {
        logic [8:0] page;
        logic [8:0] off;
    } flash_ptr_t;

    // Header bit at which the address word is complete (24 bits).
    localparam logic [5:0] CAP_LAST  = 6'd23;
    localparam logic [5:0] OPC_LAST  = 6'd7;
    localparam logic [5:0] HDR_MAIN  = 6'd56;
    localparam logic [5:0] HDR_BUF   = 6'd32;

    function automatic rd_mode_e decode_op(input logic [7:0] op);
        rd_mode_e m;
        case (op)
            8'h68, 8'hE8: m = MODE_ARRAY;
            8'h52, 8'hD2: m = MODE_PAGE;
            8'h54, 8'hD4: m = MODE_BUF;
            default:      m = MODE_NONE;
        endcase
        return m;
    endfunction

    function automatic logic [5:0] hdr_last(input rd_mode_e m);
        return (m == MODE_BUF) ? (HDR_BUF - 6'd1) : (HDR_MAIN - 6'd1);
    endfunction

endpackage

// File: rtl/sfr_frontend.sv
module sfr_frontend
    import sfr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       bit_stb,
    input  logic       bit_in,
    output fe_state_e  state,
    output rd_mode_e   mode,
    output logic [8:0] cap_page,
    output logic [8:0] cap_off,
    output logic       hdr_done
);

    logic [5:0]  cnt;
    logic [16:0] sh;

    assign hdr_done = bit_stb && !cs_n && (state == FE_HDR) && (cnt == hdr_last(mode));

    always_ff @(posedge clk) begin
        if (rst || cs_n) begin
            state <= FE_OPC;
            mode  <= MODE_NONE;
            cnt   <= '0;
            sh    <= '0;
            if (rst) begin
                cap_page <= '0;
                cap_off  <= '0;
            end
        end else if (bit_stb) begin
            sh <= {sh[15:0], bit_in};
            case (state)
                FE_OPC: begin
                    if (cnt == OPC_LAST) begin
                        mode  <= decode_op({sh[6:0], bit_in});
                        state <= (decode_op({sh[6:0], bit_in}) == MODE_NONE) ? FE_SKIP : FE_HDR;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 6'd1;
                    end
                end
                FE_HDR: begin
                    cnt <= cnt + 6'd1;
                    if (cnt == CAP_LAST) begin
                        cap_page <= sh[16:8];
                        cap_off  <= {sh[7:0], bit_in};
                    end
                    if (cnt == hdr_last(mode)) begin
                        state <= FE_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sfr_addr_gen.sv
module sfr_addr_gen
    import sfr_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 264
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       step,
    input  rd_mode_e   mode,
    input  logic [8:0] cap_page,
    input  logic [8:0] cap_off,
    output flash_ptr_t ptr
);

    localparam logic [8:0] LAST_OFF  = 9'(PAGE_BYTES - 1);
    localparam logic [8:0] LAST_PAGE = 9'(NUM_PAGES - 1);
    localparam logic [8:0] PAGE_MASK = 9'(NUM_PAGES - 1);

    flash_ptr_t nxt;

    always_comb begin
        nxt = ptr;
        if (ptr.off >= LAST_OFF) begin
            nxt.off = '0;
            if (mode == MODE_ARRAY) begin
                nxt.page = (ptr.page >= LAST_PAGE) ? 9'd0 : ptr.page + 9'd1;
            end
        end else begin
            nxt.off = ptr.off + 9'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr.page <= (mode == MODE_BUF) ? 9'd0 : (cap_page & PAGE_MASK);
            ptr.off  <= cap_off;
        end else if (step) begin
            ptr <= nxt;
        end
    end

endmodule

// File: rtl/sfr_store.sv
module sfr_store
    import sfr_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 264,
    parameter int MAIN_AW    = $clog2(NUM_PAGES * PAGE_BYTES + 1)
) (
    input  logic               clk,
    input  logic               bd_we,
    input  logic               bd_sel_buf,
    input  logic [MAIN_AW-1:0] bd_addr,
    input  logic [7:0]         bd_wdata,
    input  rd_mode_e           mode,
    input  flash_ptr_t         ptr,
    output logic [7:0]         rd_byte
);

    localparam int MAIN_BYTES = NUM_PAGES * PAGE_BYTES;
    localparam int BUF_AW     = $clog2(PAGE_BYTES);
    localparam logic [MAIN_AW-1:0] MAIN_LIMIT = MAIN_AW'(MAIN_BYTES);
    localparam logic [MAIN_AW-1:0] BUF_LIMIT  = MAIN_AW'(PAGE_BYTES);
    localparam logic [8:0]         OFF_LIMIT  = 9'(PAGE_BYTES);

    logic [7:0] main_mem [MAIN_BYTES];
    logic [7:0] buf_mem  [PAGE_BYTES];
    logic [MAIN_AW-1:0] main_idx;

    // Only the backdoor writes either array; reads never do.
    always_ff @(posedge clk) begin
        if (bd_we) begin
            if (bd_sel_buf) begin
                if (bd_addr < BUF_LIMIT) buf_mem[BUF_AW'(bd_addr)] <= bd_wdata;
            end else begin
                if (bd_addr < MAIN_LIMIT) main_mem[bd_addr] <= bd_wdata;
            end
        end
    end

    assign main_idx = MAIN_AW'(ptr.page) * MAIN_AW'(PAGE_BYTES) + MAIN_AW'(ptr.off);

    always_comb begin
        rd_byte = 8'h00;
        if (ptr.off < OFF_LIMIT) begin
            if (mode == MODE_BUF) rd_byte = buf_mem[BUF_AW'(ptr.off)];
            else                  rd_byte = main_mem[main_idx];
        end
    end

endmodule

// File: rtl/sfr_tx.sv
module sfr_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       load,
    input  logic       data_act,
    input  logic       fall,
    input  logic [7:0] rd_byte,
    output logic       sdo_dat,
    output logic       sdo_oe,
    output logic       step
);

    logic [2:0] bit_idx;

    assign step = fall && data_act && !cs_n && (bit_idx == 3'd7);

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_dat <= 1'b0;
            sdo_oe  <= 1'b0;
            bit_idx <= '0;
        end else if (cs_n) begin
            sdo_oe  <= 1'b0;
            bit_idx <= '0;
        end else if (load) begin
            bit_idx <= '0;
        end else if (fall && data_act) begin
            sdo_dat <= rd_byte[3'd7 - bit_idx];
            sdo_oe  <= 1'b1;
            bit_idx <= bit_idx + 3'd1;
        end
    end

endmodule

// File: rtl/sflash_read_resp.sv
module sflash_read_resp
    import sfr_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 264,
    parameter int MAIN_AW    = $clog2(NUM_PAGES * PAGE_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               sck,
    input  logic               mosi,
    output logic               sdo_dat,
    output logic               sdo_oe,
    input  logic               bd_we,
    input  logic               bd_sel_buf,
    input  logic [MAIN_AW-1:0] bd_addr,
    input  logic [7:0]         bd_wdata
);

    logic       sck_d1, sck_d2, mosi_d1;
    logic       sck_rise, sck_fall;
    fe_state_e  fe_state;
    rd_mode_e   fe_mode;
    logic [8:0] cap_page, cap_off;
    logic       hdr_done, adv, data_act;
    flash_ptr_t ptr;
    logic [7:0] rd_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d1  <= 1'b0;
            sck_d2  <= 1'b0;
            mosi_d1 <= 1'b0;
        end else begin
            sck_d1  <= sck;
            sck_d2  <= sck_d1;
            mosi_d1 <= mosi;
        end
    end

    assign sck_rise = sck_d1 && !sck_d2;
    assign sck_fall = !sck_d1 && sck_d2;
    assign data_act = (fe_state == FE_DATA) && !cs_n;

    sfr_frontend u_fe (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .bit_stb  (sck_rise),
        .bit_in   (mosi_d1),
        .state    (fe_state),
        .mode     (fe_mode),
        .cap_page (cap_page),
        .cap_off  (cap_off),
        .hdr_done (hdr_done)
    );

    sfr_addr_gen #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_ag (
        .clk      (clk),
        .rst      (rst),
        .load     (hdr_done),
        .step     (adv),
        .mode     (fe_mode),
        .cap_page (cap_page),
        .cap_off  (cap_off),
        .ptr      (ptr)
    );

    sfr_store #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES), .MAIN_AW(MAIN_AW)) u_st (
        .clk        (clk),
        .bd_we      (bd_we),
        .bd_sel_buf (bd_sel_buf),
        .bd_addr    (bd_addr),
        .bd_wdata   (bd_wdata),
        .mode       (fe_mode),
        .ptr        (ptr),
        .rd_byte    (rd_byte)
    );

    sfr_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .load     (hdr_done),
        .data_act (data_act),
        .fall     (sck_fall),
        .rd_byte  (rd_byte),
        .sdo_dat  (sdo_dat),
        .sdo_oe   (sdo_oe),
        .step     (adv)
    );

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker
    import sfr_pkg::*;
#(
    parameter int NUM_PAGES  = 4,
    parameter int PAGE_BYTES = 264
) (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sdo_dat,
    input logic       sdo_oe,
    input logic       sck_fall,
    input logic       adv,
    input fe_state_e  fe_state,
    input rd_mode_e   fe_mode,
    input flash_ptr_t ptr
);

    localparam logic [8:0] LAST_OFF  = 9'(PAGE_BYTES - 1);
    localparam logic [8:0] LAST_PAGE = 9'(NUM_PAGES - 1);

    // R9: chip select high ends driving within one cycle
    a_r9_oe_drop: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !sdo_oe);

    // R4: the data bit moves only on a cycle carrying a falling sck edge
    a_r4_dat_on_fall: assert property (@(posedge clk) disable iff (rst)
        !sck_fall |=> $stable(sdo_dat));

    // R10: the pad is driven only in the data phase of a decoded read
    a_r10_oe_in_data: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> (fe_state == FE_DATA));

    // R7: page and buffer reads keep their page on every step
    a_r7_page_held: assert property (@(posedge clk) disable iff (rst)
        (adv && fe_mode != MODE_ARRAY) |=> $stable(ptr.page));

    // R5: array sweep leaves the last offset for offset 0 of the next page
    a_r5_page_step: assert property (@(posedge clk) disable iff (rst)
        (adv && fe_mode == MODE_ARRAY && ptr.off == LAST_OFF) |=>
        (ptr.off == 9'd0) &&
        (ptr.page == (($past(ptr.page) == LAST_PAGE) ? 9'd0 : $past(ptr.page) + 9'd1)));

endmodule

bind sflash_read_resp sfr_checker #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sdo_dat  (sdo_dat),
    .sdo_oe   (sdo_oe),
    .sck_fall (sck_fall),
    .adv      (adv),
    .fe_state (fe_state),
    .fe_mode  (fe_mode),
    .ptr      (ptr)
);

// File: tb/tb_sflash_read_resp.sv
module tb_sflash_read_resp;

    localparam int NP = 4;
    localparam int PB = 264;
    localparam int AW = $clog2(NP * PB + 1);

    typedef struct packed {
        logic [7:0] op;
        logic [8:0] page;
        logic [8:0] off;
        logic [5:0] res;
        logic [3:0] n;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h68, 9'd0,   9'd260, 6'd0,    4'd6},  // R5 crossover into page 1
        '{8'hE8, 9'd3,   9'd262, 6'd0,    4'd4},  // R6 last page back to page 0
        '{8'h52, 9'd2,   9'd261, 6'd0,    4'd5},  // R7 wrap inside page 2
        '{8'hD2, 9'd1,   9'd0,   6'd0,    4'd3},  // R2 second opcode
        '{8'h54, 9'd0,   9'd262, 6'd0,    4'd4},  // R8 buffer wrap
        '{8'hD4, 9'd0,   9'd100, 6'd0,    4'd3},  // R3 second opcode
        '{8'h68, 9'd5,   9'd10,  6'h2A,   4'd2},  // R1 reserved bits, page folding
        '{8'hE8, 9'd1,   9'd263, 6'd0,    4'd2}   // R1 second opcode
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, cs_n, sck, mosi, bd_we, bd_sel_buf;
    logic [AW-1:0] bd_addr;
    logic [7:0] bd_wdata;
    logic sdo_dat, sdo_oe;

    int n_checks = 0;
    int n_fail = 0;

    sflash_read_resp #(.NUM_PAGES(NP), .PAGE_BYTES(PB)) dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .sdo_dat(sdo_dat), .sdo_oe(sdo_oe),
        .bd_we(bd_we), .bd_sel_buf(bd_sel_buf), .bd_addr(bd_addr), .bd_wdata(bd_wdata)
    );

    function automatic logic [7:0] main_pat(int p, int o);
        return 8'((p * 29 + o * 7 + 1) & 255);
    endfunction

    function automatic logic [7:0] buf_pat(int o);
        return 8'((o * 13 + 65) & 255) ^ 8'hA5;
    endfunction

    function automatic string vec_tag(int i);
        case (i)
            0: return "R5";
            1: return "R6";
            2: return "R7";
            3: return "R2";
            4: return "R8";
            5: return "R3";
            default: return "R1";
        endcase
    endfunction

    function automatic int op_kind(logic [7:0] op);
        case (op)
            8'h68, 8'hE8: return 1;
            8'h52, 8'hD2: return 2;
            8'h54, 8'hD4: return 3;
            default:      return 0;
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic send_bits(logic [63:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            sck = 1'b0; mosi = v[i]; tick(2);
            sck = 1'b1; tick(2);
        end
    endtask

    task automatic read_byte(output logic [7:0] b, output logic oe_all);
        b = '0;
        oe_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; tick(2);
            b[i] = sdo_dat;
            oe_all = oe_all & sdo_oe;
            sck = 1'b1; tick(2);
        end
    endtask

    task automatic end_cmd();
        sck = 1'b0; tick(1);
        cs_n = 1'b1; tick(3);
    endtask

    task automatic send_header(logic [7:0] op, int page, int off, logic [5:0] res);
        cs_n = 1'b0; tick(2);
        send_bits({56'h0, op}, 8);
        if (op_kind(op) == 3)
            send_bits({32'h0, 15'h7FFF, 9'(off), 8'hFF}, 32);
        else
            send_bits({8'h0, res, 9'(page), 9'(off), 32'hA5C3_0F96}, 56);
    endtask

    task automatic run_read(logic [7:0] op, int page, int off, logic [5:0] res, int n, string tag);
        int k, p, o;
        logic [7:0] b, exp;
        logic oe;
        k = op_kind(op);
        p = page % NP;
        o = off;
        send_header(op, page, off, res);
        for (int i = 0; i < n; i++) begin
            read_byte(b, oe);
            exp = (k == 3) ? buf_pat(o) : main_pat(p, o);
            check(tag, b, exp, $sformatf("op %h byte %0d", op, i));
            check(tag, {7'b0, oe}, 8'h01, $sformatf("op %h oe byte %0d", op, i));
            o++;
            if (o >= PB) begin
                o = 0;
                if (k == 1) p = (p + 1) % NP;
            end
        end
        end_cmd();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] b;
        logic oe, bit7;
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0;
        bd_we = 1'b0; bd_sel_buf = 1'b0; bd_addr = '0; bd_wdata = '0;
        tick(4);
        check("R12", {6'b0, sdo_oe, sdo_dat}, 8'h00, "outputs in reset");
        rst = 1'b0;
        tick(2);
        check("R12", {6'b0, sdo_oe, sdo_dat}, 8'h00, "outputs after reset");

        // R13: preload both arrays through the backdoor
        for (int p = 0; p < NP; p++) begin
            for (int o = 0; o < PB; o++) begin
                bd_we = 1'b1; bd_sel_buf = 1'b0; bd_addr = AW'(p * PB + o); bd_wdata = main_pat(p, o);
                tick(1);
            end
        end
        for (int o = 0; o < PB; o++) begin
            bd_we = 1'b1; bd_sel_buf = 1'b1; bd_addr = AW'(o); bd_wdata = buf_pat(o);
            tick(1);
        end
        bd_we = 1'b0;
        tick(2);

        for (int i = 0; i < NV; i++) begin
            run_read(VECS[i].op, int'(VECS[i].page), int'(VECS[i].off), VECS[i].res,
                     int'(VECS[i].n), vec_tag(i));
        end

        // R4: data holds across the rising edge, MSB comes first
        send_header(8'h54, 0, 1, 6'd0);
        sck = 1'b0; tick(2);
        bit7 = sdo_dat;
        check("R4", {7'b0, bit7}, {7'b0, buf_pat(1)[7]}, "first bit is MSB");
        sck = 1'b1; tick(2);
        check("R4", {7'b0, sdo_dat}, {7'b0, bit7}, "bit held over rising edge");
        end_cmd();

        // R10: unknown command byte keeps the pad released
        cs_n = 1'b0; tick(2);
        send_bits(64'h0F, 8);
        oe = 1'b0;
        for (int i = 0; i < 40; i++) begin
            sck = 1'b0; tick(2);
            oe = oe | sdo_oe;
            sck = 1'b1; tick(2);
        end
        check("R10", {7'b0, oe}, 8'h00, "oe after unknown opcode");
        end_cmd();
        run_read(8'h52, 3, 7, 6'd0, 1, "R10");

        // R9: abort mid-byte, then a fresh command decodes
        send_header(8'h68, 1, 3, 6'd0);
        read_byte(b, oe);
        check("R9", b, main_pat(1, 3), "byte before abort");
        for (int i = 0; i < 3; i++) begin
            sck = 1'b0; tick(2); sck = 1'b1; tick(2);
        end
        cs_n = 1'b1; tick(2);
        check("R9", {7'b0, sdo_oe}, 8'h00, "oe after chip select high");
        tick(2);
        run_read(8'h52, 3, 7, 6'd0, 2, "R9");

        // R11: buffer unchanged after all main reads
        run_read(8'h54, 0, 0, 6'd0, 4, "R11");

        // R13: single backdoor overwrite seen by a page read
        bd_we = 1'b1; bd_sel_buf = 1'b0; bd_addr = AW'(2 * PB + 5); bd_wdata = 8'hC3;
        tick(1);
        bd_we = 1'b0;
        tick(1);
        send_header(8'h52, 2, 5, 6'd0);
        read_byte(b, oe);
        check("R13", b, 8'hC3, "backdoor overwritten byte");
        end_cmd();

        report();
        $finish;
    end

endmodule